// File: doc/BRIEF.md
# Serial Transceiver with Power-Mode Freeze

This block is a full-duplex asynchronous serial transceiver. Each frame has one low start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd) and one high stop bit. The receiver takes sixteen samples per bit. Seven sticky status flags report receiver and transmitter events, and each flag can drive a shared interrupt request through its own enable bit. Software reaches the block through a small port with one address, a write strobe and a read mux.

A processor-side power-mode input selects run, wait or stop. Run always lets the block operate. Stop always freezes it. Wait freezes it only when the control register's freeze-in-wait bit is set. A frozen block takes no sample ticks. The tick counter, both shift registers and all frame state keep their values, so a frame that was cut mid-bit continues from that exact tick once the mode returns to run. An asynchronous reset, whether or not the block is frozen, ends any frame and restores every register to its reset value. No clock is gated: one clock enable holds all timing state.

Register map, selected by `addr`: 0 is the divisor; 1 is control; 2 writes transmit data or reads received data; 3 reads the flags, and writing 1 to a flag bit clears it.

Top module: `uart_freeze`

## Requirements
- R1: While the block is active and the divisor DIV (register 0) is at least 1, a sample tick occurs every DIV clock cycles. Each bit lasts 16 ticks.
- R2: A write to register 2 while transmit enable (control bit 0) is set and no frame is in progress starts a frame on `txd` on the next clock. The frame is a 0 start bit, data bits 0 to 7, a parity bit if control bit 2 is set (even parity, or odd if control bit 3 is set), then a 1 stop bit. A write while a frame is in progress, or while transmit enable is clear, is ignored. `txd` idles high.
- R3: Flag bit 0 (transmit complete) is 1 after reset. It is set when the stop bit ends and cleared when a new frame is loaded.
- R4: When receive enable (control bit 1) is set, a low line at a tick starts reception. Each bit is the majority of its samples 7, 8 and 9. When the stop bit is decided, the byte appears in register 2 and flag bit 1 (receive full) is set.
- R5: Flag bit 4 (noise) is set with the received byte if samples 7, 8 and 9 of any bit in the frame disagree.
- R6: Flag bit 5 (framing) is set when the stop bit is decided as 0.
- R7: With parity enabled, flag bit 6 (parity) is set when the received parity bit does not match the parity selected by control bit 3. A matching bit leaves the flag clear.
- R8: A frame that completes while flag bit 1 is still set sets flag bit 3 (overrun). Register 2 keeps its old byte.
- R9: Flag bit 2 (idle) is set once the line has stayed high for 160 ticks after a received frame. It is set once per received frame.
- R10: `irq` is high exactly when some flag bit n is set and its enable, control bit 5+n, is set. Writing 1 to a flag bit at register 3 clears that flag.
- R11: In run mode (`pmode`=0), and in wait mode (`pmode`=1) with the freeze bit (control bit 4) clear, the block operates normally.
- R12: In wait mode with the freeze bit set, or in stop mode (`pmode`=2 or 3), no tick occurs and transmit and receive state are held. On return to run, frames continue from the point where they stopped.
- R13: Writing the freeze bit leaves the enable bits as written. Control reads back unchanged in every mode.
- R14: Reset while frozen aborts any frame: `txd` goes high, the flags read 1 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pmode | input | 2 | Power mode: 0 run, 1 wait, 2 or 3 stop |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for read and write |
| wr_data | input | 13 | Write data |
| rd_data | output | 13 | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
`txd` changes on the clock after a data write loads a frame. After that it changes only on tick edges, so a behavioural model in the bench predicts `txd` for every cycle and is compared 3 ns after each rising edge. Receive flags and the received byte change on the clock after the tick that decides the stop bit, which is sample 9 of that bit. The bench drives the line on its own tick count and reads flags only after the full stop bit. Reads are combinational and are sampled one nanosecond after the address is set. Frozen periods are checked by holding `txd` and the flags across hundreds of cycles.

// File: rtl/uart_freeze.sv
module uart_freeze #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pmode,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] rd_data,
  input  logic             rxd,
  output logic             txd,
  output logic             irq
);
  localparam logic [1:0] PM_RUN = 2'd0, PM_WAIT = 2'd1;
  localparam int NFLAG = 7;

  logic [DIV_W-1:0] div, cnt;
  logic [11:0] ctrl;
  logic [NFLAG-1:0] flags;
  logic [7:0] rx_data;

  wire te = ctrl[0], re = ctrl[1], pen = ctrl[2], podd = ctrl[3], wfz = ctrl[4];
  wire [NFLAG-1:0] ie = ctrl[11:5];
  wire active = (pmode == PM_RUN) || (pmode == PM_WAIT && !wfz);
  wire tick = active && div != '0 && cnt >= div - DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0;
      ctrl <= '0;
    end else if (wr_en) begin
      if (addr == 2'd0) div <= wr_data;
      if (addr == 2'd1) ctrl <= wr_data[11:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (active && div != '0) cnt <= tick ? '0 : cnt + 1'b1;

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && div > DIV_W'(1) && !wr_en |=> !tick);

  // transmitter
  logic [10:0] tx_sh;
  logic [3:0]  tx_left, tx_sub;
  wire tx_busy = tx_left != 4'd0;
  wire tx_load = wr_en && addr == 2'd2 && te && !tx_busy;
  wire tx_end  = tick && tx_busy && tx_sub == 4'd15 && tx_left == 4'd1;
  wire [7:0] tx_d = wr_data[7:0];
  wire tx_par = ^tx_d ^ podd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '1;
      tx_left <= '0;
      tx_sub <= '0;
    end else if (tx_load) begin
      tx_sh <= pen ? {1'b1, tx_par, tx_d, 1'b0} : {2'b11, tx_d, 1'b0};
      tx_left <= pen ? 4'd11 : 4'd10;
      tx_sub <= '0;
    end else if (tick && tx_busy) begin
      tx_sub <= tx_sub + 1'b1;
      if (tx_sub == 4'd15) begin
        tx_sh <= {1'b1, tx_sh[10:1]};
        tx_left <= tx_left - 1'b1;
      end
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && tx_busy |=> $stable(txd));

  // receiver
  logic [1:0] rsync;
  logic       rx_busy, rx_s7, rx_s8, rx_pbit, rx_noise, idle_arm;
  logic [3:0] rx_sub, rx_idx;
  logic [7:0] rx_sh, idle_cnt;
  wire rxd_s = rsync[1];
  wire samp = tick && re && rx_busy && rx_sub == 4'd9;
  wire vote = (rx_s7 & rx_s8) | (rx_s7 & rxd_s) | (rx_s8 & rxd_s);
  wire nz = !(rx_s7 == rx_s8 && rx_s8 == rxd_s);
  wire [3:0] stop_idx = pen ? 4'd10 : 4'd9;
  wire rx_done = samp && rx_idx == stop_idx;
  wire par_bad = pen && (rx_pbit != (^rx_sh ^ podd));
  wire idle_hit = tick && re && !rx_busy && rxd_s && idle_arm && idle_cnt == 8'd159;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b11;
    else rsync <= {rsync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_sub <= '0;
      rx_idx <= '0;
      rx_sh <= '0;
      rx_s7 <= 1'b1;
      rx_s8 <= 1'b1;
      rx_pbit <= 1'b0;
      rx_noise <= 1'b0;
    end else if (!re) begin
      rx_busy <= 1'b0;
    end else if (tick) begin
      if (!rx_busy) begin
        if (!rxd_s) begin
          rx_busy <= 1'b1;
          rx_sub <= 4'd1;
          rx_idx <= '0;
          rx_noise <= 1'b0;
        end
      end else begin
        rx_sub <= rx_sub + 1'b1;
        if (rx_sub == 4'd15) rx_idx <= rx_idx + 1'b1;
        if (rx_sub == 4'd7) rx_s7 <= rxd_s;
        if (rx_sub == 4'd8) rx_s8 <= rxd_s;
        if (rx_sub == 4'd9) begin
          rx_noise <= rx_noise | nz;
          if (rx_idx == 4'd0) begin
            if (vote) rx_busy <= 1'b0;
          end else if (rx_idx <= 4'd8) rx_sh <= {vote, rx_sh[7:1]};
          else if (rx_idx == stop_idx) rx_busy <= 1'b0;
          else rx_pbit <= vote;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_cnt <= '0;
      idle_arm <= 1'b0;
    end else if (rx_done) begin
      idle_cnt <= '0;
      idle_arm <= 1'b1;
    end else if (tick) begin
      if (rx_busy || !rxd_s || !re) idle_cnt <= '0;
      else if (idle_arm) begin
        idle_cnt <= idle_hit ? 8'd0 : idle_cnt + 1'b1;
        if (idle_hit) idle_arm <= 1'b0;
      end
    end

  // flags: 0 tc, 1 rx full, 2 idle, 3 overrun, 4 noise, 5 framing, 6 parity
  wire fresh = rx_done && !flags[1];
  wire [NFLAG-1:0] fset = {fresh && par_bad, fresh && !vote, fresh && (rx_noise | nz),
                           rx_done && flags[1], idle_hit, fresh, tx_end};
  wire [NFLAG-1:0] fclr = ((wr_en && addr == 2'd3) ? wr_data[NFLAG-1:0] : '0)
                          | {{(NFLAG-1){1'b0}}, tx_load};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= 7'd1;
      rx_data <= '0;
    end else begin
      flags <= (flags & ~fclr) | fset;
      if (fresh) rx_data <= rx_sh;
    end

  assign irq = |(flags & ie);

  always_comb
    case (addr)
      2'd0:    rd_data = div;
      2'd1:    rd_data = DIV_W'(ctrl);
      2'd2:    rd_data = DIV_W'(rx_data);
      default: rd_data = DIV_W'(flags);
    endcase

  // R3
  tc_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> flags[0]);

  // R4
  rxf_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !flags[1] |=> flags[1]);

  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && flags[1] |=> flags[3] && $stable(rx_data));

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && rx_busy && re && !wr_en |=> $stable(rx_sub) && rx_busy);
endmodule

// File: tb/tb_uart_freeze.sv
module tb_uart_freeze;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pmode = 2'd0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [12:0] wr_data = '0;
  logic [12:0] rd_data;
  logic rxd = 1'b1;
  logic txd, irq;

  uart_freeze dut (.clk(clk), .rst_n(rst_n), .pmode(pmode), .wr_en(wr_en), .addr(addr),
                   .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .txd(txd), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model of tick and transmit line
  int m_cnt = 0, m_sub = 0, tick_total = 0;
  int m_div = 0;
  bit m_te = 0, m_pen = 0, m_podd = 0, m_wfz = 0;
  bit act, tk, busy_old;
  logic q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sub = 0; m_div = 0;
      m_te = 0; m_pen = 0; m_podd = 0; m_wfz = 0;
      q.delete();
    end else begin
      act = (pmode == 2'd0) || (pmode == 2'd1 && !m_wfz);
      tk = act && m_div != 0 && m_cnt >= m_div - 1;
      if (act && m_div != 0) m_cnt = tk ? 0 : m_cnt + 1;
      busy_old = q.size() != 0;
      if (tk) tick_total++;
      if (tk && busy_old) begin
        m_sub++;
        if (m_sub == 16) begin m_sub = 0; void'(q.pop_front()); end
      end
      if (wr_en && addr == 2'd0) m_div = int'(wr_data);
      if (wr_en && addr == 2'd1) begin
        m_te = wr_data[0]; m_pen = wr_data[2]; m_podd = wr_data[3]; m_wfz = wr_data[4];
      end
      if (wr_en && addr == 2'd2 && m_te && !busy_old) begin
        q.push_back(1'b0);
        for (int i = 0; i < 8; i++) q.push_back(wr_data[i]);
        if (m_pen) q.push_back(^wr_data[7:0] ^ m_podd);
        q.push_back(1'b1);
        m_sub = 0;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      checks++;
      if (txd !== ((q.size() != 0) ? q[0] : 1'b1)) begin
        errors++;
        $display("FAIL R1 R2 txd per-cycle: actual %b expected %b at %0t", txd,
                 (q.size() != 0) ? q[0] : 1'b1, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [12:0] a, input logic [12:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [12:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [12:0] v);
    @(posedge clk); #1 addr = a; wr_en = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = tick_total + n;
    while (tick_total < target) @(posedge clk);
    #1;
  endtask

  task automatic tx_wait();
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic rx_frame(input logic [7:0] d, input int pbit, input bit stopv,
                          input int glitch, input int frz);
    logic bits[$];
    bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) bits.push_back(d[i]);
    if (pbit >= 0) bits.push_back(pbit[0]);
    bits.push_back(stopv);
    wait_ticks(1);
    for (int i = 0; i < bits.size(); i++) begin
      rxd = bits[i];
      if (glitch == i) begin
        wait_ticks(8); rxd = ~bits[i]; wait_ticks(1); rxd = bits[i]; wait_ticks(7);
      end else if (frz == i) begin
        wait_ticks(5); pmode = 2'd2;
        repeat (120) @(posedge clk);
        #1 pmode = 2'd0;
        wait_ticks(11);
      end else wait_ticks(16);
    end
    rxd = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] v;
    logic t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(2'd0, v); chk("R14 reset divisor", v, 13'd0);
    rd(2'd3, v); chk("R3 reset flags", v, 13'd1);
    chk("R2 idle txd", {12'd0, txd}, 13'd1);
    chk("R10 reset irq", {12'd0, irq}, 13'd0);

    wr(2'd0, 13'd4);
    wr(2'd1, 13'd3);

    wr(2'd2, 13'h0A5); tx_wait();
    rd(2'd3, v); chk("R3 tc after frame", v & 13'd1, 13'd1);

    wr(2'd2, 13'h03C);
    rd(2'd3, v); chk("R3 tc cleared by load", v & 13'd1, 13'd0);
    wr(2'd2, 13'h0FF);   // R2: ignored while busy
    tx_wait();

    wr(2'd1, 13'd2);
    wr(2'd2, 13'h055);
    repeat (10) @(posedge clk); #1;
    chk("R2 write ignored with te clear: txd", {12'd0, txd}, 13'd1);
    rd(2'd3, v); chk("R2 write ignored with te clear: tc", v & 13'd1, 13'd1);

    wr(2'd1, 13'd15);
    wr(2'd2, 13'h081); tx_wait();
    wr(2'd1, 13'd3);

    wr(2'd2, 13'h096);
    repeat (40) @(posedge clk); #1 pmode = 2'd1;
    tx_wait();
    rd(2'd3, v); chk("R11 frame completes in wait without freeze", v & 13'd1, 13'd1);
    pmode = 2'd0;

    wr(2'd1, 13'd19);
    rd(2'd1, v); chk("R13 enables kept with freeze bit", v, 13'd19);
    wr(2'd2, 13'h069);
    repeat (100) @(posedge clk); #1 pmode = 2'd1;
    repeat (2) @(posedge clk); #1 t0 = txd;
    repeat (200) @(posedge clk); #1;
    chk("R12 txd held in frozen wait", {12'd0, txd}, {12'd0, t0});
    rd(2'd3, v); chk("R12 frame not finished while frozen", v & 13'd1, 13'd0);
    rd(2'd1, v); chk("R13 control unchanged in wait", v, 13'd19);
    pmode = 2'd0;
    tx_wait();
    rd(2'd3, v); chk("R12 frame resumes and completes", v & 13'd1, 13'd1);

    wr(2'd1, 13'd3);
    wr(2'd2, 13'h0C3);
    repeat (150) @(posedge clk); #1 pmode = 2'd2;
    repeat (2) @(posedge clk); #1 t0 = txd;
    repeat (200) @(posedge clk); #1;
    chk("R12 txd held in stop", {12'd0, txd}, {12'd0, t0});
    pmode = 2'd0;
    tx_wait();

    wr(2'd3, 13'h7F);
    rx_frame(8'h5A, -1, 1'b1, -1, -1);
    rd(2'd3, v); chk("R4 receive full", v & 13'h72, 13'h02);
    rd(2'd2, v); chk("R4 received byte", v, 13'h05A);

    wr(2'd3, 13'h7F);
    rx_frame(8'h33, -1, 1'b1, 3, -1);
    rd(2'd2, v); chk("R5 majority keeps byte", v, 13'h033);
    rd(2'd3, v); chk("R5 noise flag", v & 13'h10, 13'h10);

    wr(2'd3, 13'h7F);
    rx_frame(8'hC6, -1, 1'b1, -1, 4);
    rd(2'd2, v); chk("R12 frozen reception resumes", v, 13'h0C6);
    rd(2'd3, v); chk("R12 resumed frame clean", v & 13'h72, 13'h02);

    wr(2'd3, 13'h7F);
    rx_frame(8'h0F, -1, 1'b0, -1, -1);
    wait_ticks(40);
    rd(2'd3, v); chk("R6 framing flag", v & 13'h20, 13'h20);

    wr(2'd1, 13'd7);
    wr(2'd3, 13'h7F);
    rx_frame(8'h01, 0, 1'b1, -1, -1);
    rd(2'd3, v); chk("R7 parity flag on mismatch", v & 13'h40, 13'h40);
    wr(2'd3, 13'h7F);
    rx_frame(8'h03, 0, 1'b1, -1, -1);
    rd(2'd3, v); chk("R7 no parity flag on match", v & 13'h42, 13'h02);
    rd(2'd2, v); chk("R7 byte with parity", v, 13'h003);
    wr(2'd1, 13'd3);

    wr(2'd3, 13'h7F);
    rx_frame(8'h11, -1, 1'b1, -1, -1);
    rx_frame(8'h22, -1, 1'b1, -1, -1);
    rd(2'd3, v); chk("R8 overrun flag", v & 13'h08, 13'h08);
    rd(2'd2, v); chk("R8 old byte kept", v, 13'h011);

    wr(2'd3, 13'h7F);
    rx_frame(8'h44, -1, 1'b1, -1, -1);
    wr(2'd3, 13'h7F);
    wait_ticks(100);
    rd(2'd3, v); chk("R9 idle not yet", v & 13'h04, 13'h00);
    wait_ticks(80);
    rd(2'd3, v); chk("R9 idle set", v & 13'h04, 13'h04);

    wr(2'd3, 13'h7F);
    wr(2'd1, 13'd67);
    chk("R10 irq low before frame", {12'd0, irq}, 13'd0);
    rx_frame(8'h7E, -1, 1'b1, -1, -1);
    #1 chk("R10 irq on receive full", {12'd0, irq}, 13'd1);
    wr(2'd3, 13'h02);
    #1 chk("R10 irq cleared with flag", {12'd0, irq}, 13'd0);

    wr(2'd1, 13'd3);
    wr(2'd2, 13'h05A);
    repeat (60) @(posedge clk); #1 pmode = 2'd2;
    repeat (10) @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk); #1 rst_n = 1'b1;
    chk("R14 txd high after reset", {12'd0, txd}, 13'd1);
    rd(2'd3, v); chk("R14 flags after reset", v, 13'd1);
    rd(2'd1, v); chk("R14 control after reset", v, 13'd0);
    rd(2'd0, v); chk("R14 divisor after reset", v, 13'd0);
    pmode = 2'd0;
    repeat (5) @(posedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule